// File: doc/BRIEF.md
# Valid/Invalid Coherence Line Controller

This block is the coherence engine of one private write-back cache in a multi-core system that allows only a single cached copy of any block. It tracks a small set of lines, each holding a state bit (Invalid or Valid) and one data word. The local core issues loads and stores through a request port. A request that finds its line Valid is completed locally on the next cycle with no interconnect traffic. A request that finds its line Invalid raises a one-cycle miss on the interconnect, tagged as a load miss or a store miss. Further local requests are held off until the fill data comes back.

The interconnect forwards every miss to the other controllers as a snoop. A controller whose line is Valid answers the next cycle with its data and drops the line to Invalid. This applies to read-only copies too, so a remote load miss also strips the local copy. When no cache answers, the interconnect takes the word from memory. Snoops are accepted one per cycle and answered in the order they arrive. A local request to the line being snooped in that same cycle is refused, so the snoop acts first.

Top module: `vi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `miss_valid` and `snoop_rsp_valid` are 0.
- R2: A load or store accepted (`cpu_req_valid` and `cpu_req_ready` high at a clock edge) to a Valid line gives `cpu_rsp_valid` one cycle later, with no `miss_valid`. The response carries the line word for a load and the written word for a store, and a store updates the line.
- R3: A load accepted to an Invalid line raises `miss_valid` for exactly one cycle, one cycle after acceptance, with `miss_is_store`=0 and `miss_addr` equal to the line index. One cycle after `fill_valid`, `cpu_rsp_valid` returns the fill word and the line becomes Valid holding it.
- R4: A store accepted to an Invalid line issues its miss with `miss_is_store`=1. When the fill arrives the line becomes Valid holding the store word rather than the fill word, and the response one cycle later carries the store word.
- R5: From the cycle `miss_valid` is high until the fill has been taken, `cpu_req_ready` is 0 and a held request is not accepted.
- R6: A snoop to a Valid line gives `snoop_rsp_valid`=1 and `snoop_rsp_hit`=1 one cycle later, with the line word on `snoop_rsp_data`, and the line becomes Invalid, so the next local access to it misses. Snoops on consecutive cycles are each answered on the following cycle, in arrival order.
- R7: A snoop to an Invalid line gives `snoop_rsp_valid`=1 with `snoop_rsp_hit`=0 one cycle later and changes no line.
- R8: When `snoop_valid` and `cpu_req_valid` are high in the same cycle with `snoop_addr` equal to `cpu_req_addr`, `cpu_req_ready` is 0 in that cycle. The snoop is served first, and the retried request then misses.
- R9: With two controllers and a memory behind an interconnect, every load returns the most recently stored word for its address, and at most one controller holds a given line Valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Local request present |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | clog2(LINES) | Line index of the request |
| cpu_req_wdata | input | DW | Store word |
| cpu_req_ready | output | 1 | Request accepted at this edge when high |
| cpu_rsp_valid | output | 1 | Local access completed |
| cpu_rsp_rdata | output | DW | Loaded word, or stored word for a store |
| miss_valid | output | 1 | One-cycle miss request to the interconnect |
| miss_is_store | output | 1 | 1 = store miss, 0 = load miss |
| miss_addr | output | clog2(LINES) | Line index of the miss |
| fill_valid | input | 1 | Data for the outstanding miss |
| fill_data | input | DW | Fill word |
| snoop_valid | input | 1 | Another core's miss observed |
| snoop_addr | input | clog2(LINES) | Line index of the remote miss |
| snoop_rsp_valid | output | 1 | Snoop answered (one cycle after snoop_valid) |
| snoop_rsp_hit | output | 1 | This controller held the line and supplies it |
| snoop_rsp_data | output | DW | Supplied word |

## Verification
The bench sweeps every line through load-miss, store-hit and load-hit on both controllers, then runs a long pseudo-random mix in which ownership moves back and forth. A controller that kept its copy after a remote load miss would break the single-copy rule and later return a stale word. One that let the fill word overwrite a pending store would lose that store. Directed cases cover a snoop colliding with a local request to the same line, where a design without the refusal would complete a hit on a line it has just given away. They also cover snoops on back-to-back cycles, where an out-of-order or dropped answer shows up as wrong data. A controller that accepted requests during an outstanding miss would show `cpu_req_ready` high while waiting for fill.

// File: rtl/vi_pkg.sv
`timescale 1ns/1ps
package vi_pkg;

    typedef enum logic {
        LINE_INV = 1'b0,
        LINE_VAL = 1'b1
    } line_state_e;

    typedef enum logic {
        MISS_IDLE = 1'b0,
        MISS_WAIT = 1'b1
    } miss_phase_e;

endpackage

// File: rtl/vi_line_store.sv
`timescale 1ns/1ps
// Per-line state bit and data word, one write port, one invalidate port
// and two read ports (local side and snoop side).
module vi_line_store
    import vi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int DW    = 16,
    parameter int AW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              inv_en,
    input  logic [AW-1:0]     inv_addr,
    input  logic [AW-1:0]     loc_addr,
    output line_state_e       loc_state,
    output logic [DW-1:0]     loc_data,
    input  logic [AW-1:0]     snp_addr,
    output line_state_e       snp_state,
    output logic [DW-1:0]     snp_data
);

    typedef struct packed {
        line_state_e       st;
        logic [DW-1:0]     data;
    } line_t;

    line_state_e       st_arr   [LINES];
    logic [DW-1:0]     data_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t line_d;
        line_t line_q;

        always_comb begin
            line_d = line_q;
            if (wr_en && (wr_addr == AW'(g))) begin
                line_d.st   = LINE_VAL;
                line_d.data = wr_data;
            end
            if (inv_en && (inv_addr == AW'(g))) begin
                line_d.st = LINE_INV;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q <= '{st: LINE_INV, data: '0};
            end else begin
                line_q <= line_d;
            end
        end

        assign st_arr[g]   = line_q.st;
        assign data_arr[g] = line_q.data;
    end

    assign loc_state = st_arr[loc_addr];
    assign loc_data  = data_arr[loc_addr];
    assign snp_state = st_arr[snp_addr];
    assign snp_data  = data_arr[snp_addr];

endmodule

// File: rtl/vi_miss_ctrl.sv
`timescale 1ns/1ps
// Holds the single outstanding miss: emits the request pulse, waits for
// fill, and produces the word to install (store word wins over fill).
module vi_miss_ctrl
    import vi_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic              start_store,
    input  logic [DW-1:0]     start_wdata,
    input  logic              fill_valid,
    input  logic [DW-1:0]     fill_data,
    output logic              busy,
    output logic              req_pulse,
    output logic              req_store,
    output logic [AW-1:0]     req_addr,
    output logic              inst_en,
    output logic [AW-1:0]     inst_addr,
    output logic [DW-1:0]     inst_data
);

    typedef struct packed {
        miss_phase_e       phase;
        logic              pulse;
        logic              is_store;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
    } mc_t;

    mc_t mc_d;
    mc_t mc_q;

    always_comb begin
        mc_d       = mc_q;
        mc_d.pulse = 1'b0;
        inst_en    = 1'b0;
        case (mc_q.phase)
            MISS_IDLE: begin
                if (start) begin
                    mc_d.phase    = MISS_WAIT;
                    mc_d.pulse    = 1'b1;
                    mc_d.is_store = start_store;
                    mc_d.addr     = start_addr;
                    mc_d.wdata    = start_wdata;
                end
            end
            MISS_WAIT: begin
                if (fill_valid) begin
                    inst_en    = 1'b1;
                    mc_d.phase = MISS_IDLE;
                end
            end
            default: mc_d.phase = MISS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_q <= '{phase: MISS_IDLE, pulse: 1'b0, is_store: 1'b0,
                      addr: '0, wdata: '0};
        end else begin
            mc_q <= mc_d;
        end
    end

    assign busy      = (mc_q.phase == MISS_WAIT);
    assign req_pulse = mc_q.pulse;
    assign req_store = mc_q.is_store;
    assign req_addr  = mc_q.addr;
    assign inst_addr = mc_q.addr;
    assign inst_data = mc_q.is_store ? mc_q.wdata : fill_data;

endmodule

// File: rtl/vi_snoop_port.sv
`timescale 1ns/1ps
// Answers one remote miss per cycle, registered, and requests the
// invalidation of a line it gives away.
module vi_snoop_port
    import vi_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_valid,
    input  line_state_e       line_state,
    input  logic [DW-1:0]     line_data,
    output logic              inv_en,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DW-1:0]     rsp_data
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [DW-1:0]     data;
    } sr_t;

    sr_t sr_d;
    sr_t sr_q;

    always_comb begin
        inv_en     = snoop_valid && (line_state == LINE_VAL);
        sr_d.valid = snoop_valid;
        sr_d.hit   = inv_en;
        sr_d.data  = inv_en ? line_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '{valid: 1'b0, hit: 1'b0, data: '0};
        end else begin
            sr_q <= sr_d;
        end
    end

    assign rsp_valid = sr_q.valid;
    assign rsp_hit   = sr_q.hit;
    assign rsp_data  = sr_q.data;

endmodule

// File: rtl/vi_line_ctrl.sv
`timescale 1ns/1ps
module vi_line_ctrl
    import vi_pkg::*;
#(
    parameter  int LINES = 4,
    parameter  int DW    = 16,
    localparam int AW    = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_we,
    input  logic [AW-1:0]     cpu_req_addr,
    input  logic [DW-1:0]     cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DW-1:0]     cpu_rsp_rdata,
    output logic              miss_valid,
    output logic              miss_is_store,
    output logic [AW-1:0]     miss_addr,
    input  logic              fill_valid,
    input  logic [DW-1:0]     fill_data,
    input  logic              snoop_valid,
    input  logic [AW-1:0]     snoop_addr,
    output logic              snoop_rsp_valid,
    output logic              snoop_rsp_hit,
    output logic [DW-1:0]     snoop_rsp_data
);

    typedef struct packed {
        logic              valid;
        logic [DW-1:0]     data;
    } rsp_t;

    line_state_e       loc_state;
    logic [DW-1:0]     loc_data;
    line_state_e       snp_state;
    logic [DW-1:0]     snp_data;
    logic              busy;
    logic              inst_en;
    logic [AW-1:0]     inst_addr;
    logic [DW-1:0]     inst_data;
    logic              inv_en;
    logic              accept;
    logic              loc_hit;
    logic              start_miss;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [DW-1:0]     wr_data;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    // A snoop to the requested line takes the cycle; the request retries.
    always_comb begin
        cpu_req_ready = !busy && !(snoop_valid && (snoop_addr == cpu_req_addr));
        accept        = cpu_req_valid && cpu_req_ready;
        loc_hit       = (loc_state == LINE_VAL);
        start_miss    = accept && !loc_hit;
        wr_en         = inst_en || (accept && loc_hit && cpu_req_we);
        wr_addr       = inst_en ? inst_addr : cpu_req_addr;
        wr_data       = inst_en ? inst_data : cpu_req_wdata;
    end

    always_comb begin
        rsp_d.valid = inst_en || (accept && loc_hit);
        if (inst_en) begin
            rsp_d.data = inst_data;
        end else if (cpu_req_we) begin
            rsp_d.data = cpu_req_wdata;
        end else begin
            rsp_d.data = loc_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, data: '0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign cpu_rsp_valid = rsp_q.valid;
    assign cpu_rsp_rdata = rsp_q.data;

    vi_line_store #(.LINES(LINES), .DW(DW), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .inv_en    (inv_en),
        .inv_addr  (snoop_addr),
        .loc_addr  (cpu_req_addr),
        .loc_state (loc_state),
        .loc_data  (loc_data),
        .snp_addr  (snoop_addr),
        .snp_state (snp_state),
        .snp_data  (snp_data)
    );

    vi_miss_ctrl #(.DW(DW), .AW(AW)) u_miss (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_miss),
        .start_addr  (cpu_req_addr),
        .start_store (cpu_req_we),
        .start_wdata (cpu_req_wdata),
        .fill_valid  (fill_valid),
        .fill_data   (fill_data),
        .busy        (busy),
        .req_pulse   (miss_valid),
        .req_store   (miss_is_store),
        .req_addr    (miss_addr),
        .inst_en     (inst_en),
        .inst_addr   (inst_addr),
        .inst_data   (inst_data)
    );

    vi_snoop_port #(.DW(DW)) u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .snoop_valid (snoop_valid),
        .line_state  (snp_state),
        .line_data   (snp_data),
        .inv_en      (inv_en),
        .rsp_valid   (snoop_rsp_valid),
        .rsp_hit     (snoop_rsp_hit),
        .rsp_data    (snoop_rsp_data)
    );

endmodule

// File: rtl/vi_line_ctrl_chk.sv
`timescale 1ns/1ps
module vi_line_ctrl_chk #(
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req_valid,
    input logic [AW-1:0] cpu_req_addr,
    input logic          cpu_req_ready,
    input logic          cpu_rsp_valid,
    input logic          miss_valid,
    input logic          fill_valid,
    input logic          snoop_valid,
    input logic [AW-1:0] snoop_addr,
    input logic          snoop_rsp_valid,
    input logic          snoop_rsp_hit
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (miss_valid) begin
            pend_q <= !fill_valid;
        end else if (fill_valid) begin
            pend_q <= 1'b0;
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!miss_valid && !cpu_rsp_valid && !snoop_rsp_valid);
        end
    end

    // R2
    accept_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> (cpu_rsp_valid != miss_valid));

    // R3
    miss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> !miss_valid);

    // R4
    fill_responds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q || miss_valid) && fill_valid) |=> cpu_rsp_valid);

    // R5
    stall_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid || pend_q) |-> !cpu_req_ready);

    // R6
    snoop_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |=> snoop_rsp_valid);

    // R7
    no_stray_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_valid |=> !snoop_rsp_valid);

    // R6
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_rsp_hit |-> snoop_rsp_valid);

    // R8
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && cpu_req_valid && (snoop_addr == cpu_req_addr)) |-> !cpu_req_ready);

endmodule

bind vi_line_ctrl vi_line_ctrl_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_req_valid   (cpu_req_valid),
    .cpu_req_addr    (cpu_req_addr),
    .cpu_req_ready   (cpu_req_ready),
    .cpu_rsp_valid   (cpu_rsp_valid),
    .miss_valid      (miss_valid),
    .fill_valid      (fill_valid),
    .snoop_valid     (snoop_valid),
    .snoop_addr      (snoop_addr),
    .snoop_rsp_valid (snoop_rsp_valid),
    .snoop_rsp_hit   (snoop_rsp_hit)
);

// File: tb/tb_vi_line_ctrl.sv
`timescale 1ns/1ps
module tb_vi_line_ctrl;

    localparam int LINES = 4;
    localparam int DW    = 16;
    localparam int AW    = 2;

    logic clk = 1'b0;
    logic rst_n;
    always #10 clk = ~clk;

    logic [1:0]    req_valid, req_we, req_ready, rsp_valid;
    logic [1:0]    miss_v, miss_st, fill_v, snp_v, snp_rv, snp_hit;
    logic [AW-1:0] req_addr [2];
    logic [AW-1:0] miss_addr [2];
    logic [AW-1:0] snp_addr [2];
    logic [DW-1:0] req_wdata [2];
    logic [DW-1:0] rsp_data [2];
    logic [DW-1:0] fill_data [2];
    logic [DW-1:0] snp_data [2];

    vi_line_ctrl #(.LINES(LINES), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(req_valid[0]), .cpu_req_we(req_we[0]),
        .cpu_req_addr(req_addr[0]), .cpu_req_wdata(req_wdata[0]),
        .cpu_req_ready(req_ready[0]), .cpu_rsp_valid(rsp_valid[0]),
        .cpu_rsp_rdata(rsp_data[0]), .miss_valid(miss_v[0]),
        .miss_is_store(miss_st[0]), .miss_addr(miss_addr[0]),
        .fill_valid(fill_v[0]), .fill_data(fill_data[0]),
        .snoop_valid(snp_v[0]), .snoop_addr(snp_addr[0]),
        .snoop_rsp_valid(snp_rv[0]), .snoop_rsp_hit(snp_hit[0]),
        .snoop_rsp_data(snp_data[0])
    );

    vi_line_ctrl #(.LINES(LINES), .DW(DW)) dut_b (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(req_valid[1]), .cpu_req_we(req_we[1]),
        .cpu_req_addr(req_addr[1]), .cpu_req_wdata(req_wdata[1]),
        .cpu_req_ready(req_ready[1]), .cpu_rsp_valid(rsp_valid[1]),
        .cpu_rsp_rdata(rsp_data[1]), .miss_valid(miss_v[1]),
        .miss_is_store(miss_st[1]), .miss_addr(miss_addr[1]),
        .fill_valid(fill_v[1]), .fill_data(fill_data[1]),
        .snoop_valid(snp_v[1]), .snoop_addr(snp_addr[1]),
        .snoop_rsp_valid(snp_rv[1]), .snoop_rsp_hit(snp_hit[1]),
        .snoop_rsp_data(snp_data[1])
    );

    int vectors = 0;
    int fails   = 0;

    logic [DW-1:0] mem  [LINES];
    logic [DW-1:0] gold [LINES];
    int            owner[LINES];
    logic [15:0]   lf;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Called at the negedge where node n shows its miss; serves it through the peer and memory.
    task automatic serve_miss(input int n, input bit we, input int a,
                              input logic [DW-1:0] wd, input logic [DW-1:0] old);
        int o = 1 - n;
        bit peer_has = (owner[a] == o);
        logic [DW-1:0] fdat;
        check("R5 ready low during miss", 32'(req_ready[n]), 32'd0);
        snp_v[o] = 1'b1; snp_addr[o] = AW'(a);
        @(negedge clk);
        snp_v[o] = 1'b0;
        check(peer_has ? "R6 peer answers" : "R7 peer answers", 32'(snp_rv[o]), 32'd1);
        check(peer_has ? "R6 peer hit" : "R7 peer miss", 32'(snp_hit[o]), 32'(peer_has));
        if (peer_has) check("R9 peer supplies latest", 32'(snp_data[o]), 32'(old));
        check("R5 ready low awaiting fill", 32'(req_ready[n]), 32'd0);
        check("R3 miss pulse single", 32'(miss_v[n]), 32'd0);
        fdat = peer_has ? snp_data[o] : mem[a];
        fill_v[n] = 1'b1; fill_data[n] = fdat;
        @(negedge clk);
        fill_v[n] = 1'b0; req_valid[n] = 1'b0;
        check(we ? "R4 fill response" : "R3 fill response", 32'(rsp_valid[n]), 32'd1);
        check(we ? "R4 store word kept" : "R9 load latest", 32'(rsp_data[n]), 32'(we ? wd : old));
        check("R5 no second miss", 32'(miss_v[n]), 32'd0);
        if (we) gold[a] = wd;
        owner[a] = n;
    endtask

    task automatic do_op(input int n, input bit we, input int a, input logic [DW-1:0] wd);
        logic [DW-1:0] old = gold[a];
        bit lhit = (owner[a] == n);
        @(negedge clk);
        req_valid[n] = 1'b1; req_we[n] = we; req_addr[n] = AW'(a); req_wdata[n] = wd;
        @(negedge clk);
        if (lhit) begin
            req_valid[n] = 1'b0;
            check("R2 hit response", 32'(rsp_valid[n]), 32'd1);
            check("R2 hit no miss", 32'(miss_v[n]), 32'd0);
            check("R2 hit data", 32'(rsp_data[n]), 32'(we ? wd : old));
            if (we) gold[a] = wd;
        end else begin
            check("R3 miss issued", {30'd0, miss_v[n], rsp_valid[n]}, 32'd2);
            check(we ? "R4 miss kind" : "R3 miss kind", 32'(miss_st[n]), 32'(we));
            check("R3 miss addr", 32'(miss_addr[n]), 32'(a));
            serve_miss(n, we, a, wd, old);
        end
    endtask

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = '0; req_we = '0; fill_v = '0; snp_v = '0;
        for (int i = 0; i < 2; i++) begin
            req_addr[i] = '0; req_wdata[i] = '0; fill_data[i] = '0; snp_addr[i] = '0;
        end
        for (int a = 0; a < LINES; a++) begin
            mem[a]   = DW'(16'hA000 + a * 16'h0111);
            gold[a]  = mem[a];
            owner[a] = -1;
        end
        lf = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check("R1 ready", 32'(req_ready[i]), 32'd1);
            check("R1 outputs idle", {29'd0, rsp_valid[i], miss_v[i], snp_rv[i]}, 32'd0);
        end

        // Sweep every line on both nodes: load miss, store hit, load hit.
        for (int a = 0; a < LINES; a++) begin
            for (int n = 0; n < 2; n++) begin
                do_op(n, 1'b0, a, '0);
                do_op(n, 1'b1, a, DW'(16'h1000 * (n + 1) + a));
                do_op(n, 1'b0, a, '0);
            end
        end
        // Store miss on a line held by the peer.
        do_op(0, 1'b1, 2, 16'h5A5A);
        do_op(1, 1'b1, 2, 16'hC3C3);
        do_op(0, 1'b0, 2, '0);

        // R6: back-to-back snoops on two lines node 0 owns.
        do_op(0, 1'b1, 0, 16'h0F0F);
        do_op(0, 1'b1, 1, 16'hF0F0);
        @(negedge clk);
        snp_v[0] = 1'b1; snp_addr[0] = 0;
        @(negedge clk);
        check("R6 first answer", {30'd0, snp_rv[0], snp_hit[0]}, 32'd3);
        check("R6 first data", 32'(snp_data[0]), 32'(gold[0]));
        mem[0] = snp_data[0]; owner[0] = -1;
        snp_addr[0] = 1;
        @(negedge clk);
        snp_v[0] = 1'b0;
        check("R6 second answer", {30'd0, snp_rv[0], snp_hit[0]}, 32'd3);
        check("R6 second data", 32'(snp_data[0]), 32'(gold[1]));
        mem[1] = snp_data[0]; owner[1] = -1;
        @(negedge clk);
        check("R7 no answer without snoop", 32'(snp_rv[0]), 32'd0);
        do_op(0, 1'b0, 0, '0);

        // R7: snoop to a line node 1 does not hold leaves its other lines alone.
        do_op(1, 1'b1, 3, 16'h7777);
        @(negedge clk);
        snp_v[1] = 1'b1; snp_addr[1] = 0;
        @(negedge clk);
        snp_v[1] = 1'b0;
        check("R7 invalid line answer", {30'd0, snp_rv[1], snp_hit[1]}, 32'd2);
        do_op(1, 1'b0, 3, '0);

        // R8: snoop and local load to the same valid line in the same cycle.
        do_op(0, 1'b1, 1, 16'h2468);
        @(negedge clk);
        req_valid[0] = 1'b1; req_we[0] = 1'b0; req_addr[0] = 1;
        snp_v[0] = 1'b1; snp_addr[0] = 1;
        #1;
        check("R8 request refused", 32'(req_ready[0]), 32'd0);
        @(negedge clk);
        snp_v[0] = 1'b0;
        check("R8 snoop served", {30'd0, snp_rv[0], snp_hit[0]}, 32'd3);
        check("R8 snoop data", 32'(snp_data[0]), 32'(gold[1]));
        check("R8 no local completion", 32'(rsp_valid[0]), 32'd0);
        mem[1] = snp_data[0]; owner[1] = -1;
        @(negedge clk);
        check("R8 retry misses", 32'(miss_v[0]), 32'd1);
        serve_miss(0, 1'b0, 1, '0, gold[1]);

        // R9: pseudo-random mix across both nodes.
        for (int k = 0; k < 400; k++) begin
            step_lf();
            do_op(int'(lf[0]), lf[1], int'(lf[3:2]), lf ^ 16'h3C5A);
        end

        summary();
        $finish;
    end

endmodule